// File: doc/BRIEF.md
# CRC-16 Frame Check Unit

This block computes the 16-bit cyclic check used by a serial field-bus frame in RTU form. A byte stream (data bits only; start, stop and parity bits never reach it) is absorbed one character at a time. The register starts at all ones. Each accepted byte is XORed into the register's low byte. The register then takes eight shift steps toward the LSB with zero fill. After each step it is XORed with the reflected constant 0xA001 whenever the bit that left the LSB was 1. By default one step is done per clock.

In transmit mode the host feeds the frame body and raises end-of-frame. The unit then pulses a result with the final check value and streams the two check bytes, low byte first. In receive mode the host feeds the whole received frame, both check bytes included. The frame passes when the register ends at zero and the frame is long enough. A frame shorter than the minimum length is always reported as failed.

Top module: `fbus_crc16_unit`

## Requirements
- R1: After reset, `ready_o` is 1, `crc_o` is 0xFFFF, and both `result_vld_o` and `chk_vld_o` are 0.
- R2: A `sof_i` taken while `ready_o` is high, with no byte in the same cycle, makes `crc_o` read 0xFFFF on the next cycle, whatever the previous value was.
- R3: A byte is accepted when `byte_vld_i` and `ready_o` are high and `eof_i` is low. After acceptance, `ready_o` stays low for exactly 8 clock cycles (8/STEPS in general) and then returns high.
- R4: A byte or a `sof_i` presented while `ready_o` is low is ignored. The check value is the same as if it had never been presented.
- R5: Each byte is XORed into bits 7:0 of the register. Then 8 steps of right shift with zero fill follow, and each step XORs in 0xA001 when the bit shifted out was 1. The bytes 01 03 00 00 00 0A starting from 0xFFFF give 0xCDC5.
- R6: In transmit mode (`mode_rx_i`=0), `result_vld_o` pulses for one cycle on the clock after end-of-frame is taken. `chk_vld_o` is high in that cycle and the following one, carrying `crc_o[7:0]` first and then `crc_o[15:8]`. `ready_o` stays low during both cycles.
- R7: In receive mode (`mode_rx_i`=1), `frame_ok_o` is 1 with the result pulse only if the register is 0x0000 after all bytes have been fed. No check bytes are emitted.
- R8: The byte count is taken from the last start-of-frame. A receive frame of fewer than 6 bytes fails. A transmit body of fewer than 4 bytes (6 less the 2 check bytes) fails.
- R9: `eof_i` is taken only while `ready_o` is high. An `eof_i` while busy produces no result, and `frame_ok_o` is 0 except during a result pulse.
- R10: A `sof_i` and a byte accepted in the same cycle start a new frame with that byte as its first byte. `eof_i` in a ready cycle takes priority, and a byte or `sof_i` in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_rx_i | input | 1 | 1 = receive check, 0 = transmit generation; sampled with end-of-frame |
| sof_i | input | 1 | Start of frame: preset the register |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Data byte (8 data bits only) |
| eof_i | input | 1 | End of frame |
| ready_o | output | 1 | High when a byte or end-of-frame can be taken |
| crc_o | output | 16 | Current register value |
| result_vld_o | output | 1 | One-cycle frame result strobe |
| frame_ok_o | output | 1 | Frame passed; valid with result_vld_o |
| chk_vld_o | output | 1 | Check byte valid (transmit mode) |
| chk_byte_o | output | 8 | Check byte, low-order first |

## Verification
The assertions assume that the host keeps inputs at their meaning: a byte strobe is a request that may be refused while busy, and end-of-frame is not repeated on consecutive ready cycles in receive mode. The bench drives every input away from the clock edge and waits for `ready_o` before each intended byte. It sends deliberate strobes, `sof_i` pulses and end-of-frame pulses only inside busy windows, where the ignore rules apply. Expected results, check values and check bytes come from a software model of the shift-and-XOR loop.

// File: rtl/fbus_crc_pkg.sv
package fbus_crc_pkg;

   localparam logic [15:0] FBUS_DEF_POLY   = 16'hA001;
   localparam logic [15:0] FBUS_DEF_PRESET = 16'hFFFF;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_EMIT  = 2'd2
   } fbus_crc_state_e;

endpackage

// File: rtl/fbus_crc_step.sv
module fbus_crc_step #(
   parameter int           W    = 16,
   parameter logic [W-1:0] POLY = 16'hA001
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] val_o
);
   logic [W-1:0] shifted;

   assign shifted = {1'b0, val_i[W-1:1]};
   assign val_o   = val_i[0] ? (shifted ^ POLY) : shifted;

endmodule

// File: rtl/fbus_crc_datapath.sv
module fbus_crc_datapath #(
   parameter int           W      = 16,
   parameter int           STEPS  = 1,
   parameter logic [W-1:0] POLY   = 16'hA001,
   parameter logic [W-1:0] PRESET = 16'hFFFF
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         absorb_i,
   input  logic         step_i,
   input  logic [7:0]   byte_i,
   output logic [W-1:0] crc_o
);
   localparam int PADW = W - 8;

   if (W < 16 || (W % 8) != 0) begin : g_bad_width
      $error("fbus_crc_datapath: W must be a multiple of 8 and at least 16");
   end
   if (STEPS != 1 && STEPS != 2 && STEPS != 4 && STEPS != 8) begin : g_bad_steps
      $error("fbus_crc_datapath: STEPS must be 1, 2, 4 or 8");
   end

   logic [W-1:0] crc_q;
   logic [W-1:0] base;
   logic [W-1:0] stage [STEPS+1];

   assign stage[0] = crc_q;

   for (genvar g = 0; g < STEPS; g++) begin : g_chain
      fbus_crc_step #(.W(W), .POLY(POLY)) i_step (
         .val_i (stage[g]),
         .val_o (stage[g+1])
      );
   end

   assign base = load_i ? PRESET : crc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         crc_q <= PRESET;
      end else if (absorb_i) begin
         crc_q <= base ^ {{PADW{1'b0}}, byte_i};
      end else if (load_i) begin
         crc_q <= PRESET;
      end else if (step_i) begin
         crc_q <= stage[STEPS];
      end
   end

   assign crc_o = crc_q;

   p_preset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !absorb_i) |=> (crc_q == PRESET));

   p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !absorb_i && !step_i) |=> $stable(crc_q));

endmodule

// File: rtl/fbus_crc_ctrl.sv
module fbus_crc_ctrl
   import fbus_crc_pkg::*;
#(
   parameter  int STEPS     = 1,
   parameter  int MIN_FRAME = 6,
   parameter  int NBYTES    = 2,
   localparam int EW        = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          sof_i,
   input  logic          byte_vld_i,
   input  logic          eof_i,
   input  logic          mode_rx_i,
   input  logic          crc_zero_i,
   output logic          ready_o,
   output logic          load_o,
   output logic          absorb_o,
   output logic          step_o,
   output logic          result_vld_o,
   output logic          frame_ok_o,
   output logic          emit_vld_o,
   output logic [EW-1:0] emit_idx_o
);
   localparam int CYC = 8 / STEPS;
   localparam int CW  = $clog2(CYC + 1);
   localparam int LW  = $clog2(MIN_FRAME + 1);

   if (MIN_FRAME <= NBYTES) begin : g_bad_min
      $error("fbus_crc_ctrl: MIN_FRAME must exceed the check field length");
   end
   if (NBYTES < 2) begin : g_bad_nbytes
      $error("fbus_crc_ctrl: NBYTES must be at least 2");
   end

   fbus_crc_state_e state_q;
   logic [CW-1:0]   left_q;
   logic [LW-1:0]   cnt_q;
   logic [EW-1:0]   idx_q;
   logic            res_q, ok_q, mode_q;
   logic            eof_take, len_rx_ok, len_tx_ok;

   assign ready_o   = (state_q == ST_IDLE);
   assign eof_take  = ready_o && eof_i;
   assign absorb_o  = ready_o && byte_vld_i && !eof_i;
   assign load_o    = ready_o && sof_i && !eof_i;
   assign step_o    = (state_q == ST_SHIFT);
   assign len_rx_ok = (cnt_q >= LW'(MIN_FRAME));
   assign len_tx_ok = (cnt_q >= LW'(MIN_FRAME - NBYTES));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         cnt_q   <= '0;
         idx_q   <= '0;
         res_q   <= 1'b0;
         ok_q    <= 1'b0;
         mode_q  <= 1'b0;
      end else begin
         res_q <= eof_take;
         if (eof_take) begin
            mode_q <= mode_rx_i;
            ok_q   <= mode_rx_i ? (crc_zero_i && len_rx_ok) : len_tx_ok;
         end else begin
            ok_q   <= 1'b0;
         end

         if (load_o) begin
            cnt_q <= absorb_o ? LW'(1) : '0;
         end else if (absorb_o && cnt_q != LW'(MIN_FRAME)) begin
            cnt_q <= cnt_q + LW'(1);
         end

         case (state_q)
            ST_IDLE: begin
               if (absorb_o) begin
                  state_q <= ST_SHIFT;
                  left_q  <= CW'(CYC);
               end else if (eof_take && !mode_rx_i) begin
                  state_q <= ST_EMIT;
                  idx_q   <= '0;
               end
            end
            ST_SHIFT: begin
               left_q <= left_q - CW'(1);
               if (left_q == CW'(1)) state_q <= ST_IDLE;
            end
            ST_EMIT: begin
               if (idx_q == EW'(NBYTES - 1)) state_q <= ST_IDLE;
               else                          idx_q   <= idx_q + EW'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign result_vld_o = res_q;
   assign frame_ok_o   = ok_q;
   assign emit_vld_o   = (state_q == ST_EMIT);
   assign emit_idx_o   = idx_q;

   // Checker state: length of the current run of shift cycles.
   logic [CW-1:0] run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     run_q <= '0;
      else if (step_o) run_q <= run_q + CW'(1);
      else             run_q <= '0;
   end

   p_accept_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      absorb_o |=> !ready_o);

   p_busy_span_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(step_o) |-> (run_q == CW'(CYC)));

   p_eof_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ready_o && eof_i) |=> !result_vld_o);

   p_ok_qual_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_ok_o |-> result_vld_o);

   p_short_fail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (result_vld_o && $past(cnt_q) < LW'(MIN_FRAME - NBYTES)) |-> !frame_ok_o);

   p_rx_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (result_vld_o && frame_ok_o && mode_q) |-> $past(crc_zero_i));

endmodule

// File: rtl/fbus_crc16_unit.sv
module fbus_crc16_unit
   import fbus_crc_pkg::*;
#(
   parameter int           W         = 16,
   parameter int           STEPS     = 1,
   parameter int           MIN_FRAME = 6,
   parameter logic [W-1:0] POLY      = FBUS_DEF_POLY,
   parameter logic [W-1:0] PRESET    = FBUS_DEF_PRESET
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         mode_rx_i,
   input  logic         sof_i,
   input  logic         byte_vld_i,
   input  logic [7:0]   byte_i,
   input  logic         eof_i,
   output logic         ready_o,
   output logic [W-1:0] crc_o,
   output logic         result_vld_o,
   output logic         frame_ok_o,
   output logic         chk_vld_o,
   output logic [7:0]   chk_byte_o
);
   localparam int NBYTES = W / 8;
   localparam int EW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   logic          load, absorb, step;
   logic [W-1:0]  crc_q;
   logic [EW-1:0] emit_idx;

   fbus_crc_datapath #(
      .W(W), .STEPS(STEPS), .POLY(POLY), .PRESET(PRESET)
   ) i_datapath (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .absorb_i (absorb),
      .step_i   (step),
      .byte_i   (byte_i),
      .crc_o    (crc_q)
   );

   fbus_crc_ctrl #(
      .STEPS(STEPS), .MIN_FRAME(MIN_FRAME), .NBYTES(NBYTES)
   ) i_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sof_i        (sof_i),
      .byte_vld_i   (byte_vld_i),
      .eof_i        (eof_i),
      .mode_rx_i    (mode_rx_i),
      .crc_zero_i   (crc_q == '0),
      .ready_o      (ready_o),
      .load_o       (load),
      .absorb_o     (absorb),
      .step_o       (step),
      .result_vld_o (result_vld_o),
      .frame_ok_o   (frame_ok_o),
      .emit_vld_o   (chk_vld_o),
      .emit_idx_o   (emit_idx)
   );

   assign crc_o      = crc_q;
   assign chk_byte_o = crc_q[8*emit_idx +: 8];

   p_chk_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chk_vld_o) |-> result_vld_o);

   p_chk_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chk_vld_o |-> (!ready_o && $stable(crc_o)));

endmodule

// File: tb/test_fbus_crc16_unit.sv
`timescale 1ns/1ps
module test_fbus_crc16_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_rx = 1'b0, sof = 1'b0, byte_vld = 1'b0, eof = 1'b0;
   logic [7:0]  byte_d = '0;
   logic        ready_o, result_vld_o, frame_ok_o, chk_vld_o;
   logic [15:0] crc_o;
   logic [7:0]  chk_byte_o;

   always #2.5 clk = ~clk;

   fbus_crc16_unit i_fbus_crc16_unit (
      .clk_i(clk), .rst_ni(rst_n), .mode_rx_i(mode_rx), .sof_i(sof),
      .byte_vld_i(byte_vld), .byte_i(byte_d), .eof_i(eof),
      .ready_o(ready_o), .crc_o(crc_o), .result_vld_o(result_vld_o),
      .frame_ok_o(frame_ok_o), .chk_vld_o(chk_vld_o), .chk_byte_o(chk_byte_o)
   );

   typedef struct { bit is_chk; logic [16:0] val; string tag; } item_t;
   item_t       sb_q[$];
   int          n_cmp = 0, n_bad = 0;
   logic [7:0]  fb [0:31];
   logic [15:0] lf = 16'hACE1;

   function automatic logic [15:0] ref_upd(logic [15:0] c, logic [7:0] b);
      c = c ^ {8'h00, b};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
      return c;
   endfunction

   task automatic check(bit ok, string tag, logic [16:0] act, logic [16:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(bit is_chk, logic [16:0] val, string tag);
      item_t it;
      it.is_chk = is_chk; it.val = val; it.tag = tag;
      sb_q.push_back(it);
   endtask

   // Monitor: pops expected items as results and check bytes appear.
   always @(negedge clk) begin
      item_t it;
      if (rst_n && result_vld_o) begin
         if (sb_q.size() == 0) check(1'b0, "R9 unexpected result", {frame_ok_o, crc_o}, '0);
         else begin
            it = sb_q.pop_front();
            check(!it.is_chk && {frame_ok_o, crc_o} == it.val, it.tag, {frame_ok_o, crc_o}, it.val);
         end
      end
      if (rst_n && chk_vld_o) begin
         if (sb_q.size() == 0) check(1'b0, "R6 unexpected check byte", {9'h0, chk_byte_o}, '0);
         else begin
            it = sb_q.pop_front();
            check(it.is_chk && {9'h0, chk_byte_o} == it.val, it.tag, {9'h0, chk_byte_o}, it.val);
         end
      end
   end

   task automatic wait_ready();
      while (!ready_o) @(negedge clk);
   endtask

   task automatic send_sof();
      wait_ready();
      sof = 1'b1;
      @(negedge clk);
      sof = 1'b0;
   endtask

   task automatic append_crc(int n);
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < n; i++) c = ref_upd(c, fb[i]);
      fb[n] = c[7:0]; fb[n+1] = c[15:8];
   endtask

   task automatic send_frame(bit rx, int n, bit merge, bit measure, bit inject);
      logic [15:0] c = 16'hFFFF;
      bit ok;
      int span;
      mode_rx = rx;
      if (!merge) send_sof();
      for (int i = 0; i < n; i++) begin
         wait_ready();
         byte_vld = 1'b1; byte_d = fb[i]; sof = merge && (i == 0);
         @(negedge clk);
         byte_vld = 1'b0; sof = 1'b0;
         c = ref_upd(c, fb[i]);
         if (measure && i == 0) begin
            span = 0;
            while (!ready_o) begin span++; @(negedge clk); end
            check(span == 8, "R3 ready low span", 17'(span), 17'd8);
         end
         if (inject && i == 1) begin
            // R4 R9: stray byte, sof and eof while busy must be ignored
            byte_vld = 1'b1; byte_d = 8'h5A; eof = 1'b1; sof = 1'b1;
            @(negedge clk);
            byte_vld = 1'b0; eof = 1'b0; sof = 1'b0;
         end
      end
      ok = rx ? (c == 16'h0000 && n >= 6) : (n >= 4);
      if (rx) push(1'b0, {ok, c}, "R7 R8 rx result");
      else begin
         push(1'b0, {ok, c}, "R6 R8 tx result");
         push(1'b1, {9'h0, c[7:0]},  "R6 check byte low");
         push(1'b1, {9'h0, c[15:8]}, "R6 check byte high");
      end
      wait_ready();
      eof = 1'b1;
      @(negedge clk);
      eof = 1'b0;
      wait_ready();
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 100000);
      check(1'b0, "watchdog expired", '0, '1);
      finish_run();
   end

   initial begin
      logic [15:0] m;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready_o == 1'b1, "R1 ready after reset", {16'h0, ready_o}, 17'd1);
      check(crc_o == 16'hFFFF, "R1 crc after reset", {1'b0, crc_o}, 17'h0FFFF);
      check(!result_vld_o && !chk_vld_o, "R1 strobes idle", {15'h0, result_vld_o, chk_vld_o}, '0);

      // R5 known vector, transmit, with R3 span measurement
      fb[0] = 8'h01; fb[1] = 8'h03; fb[2] = 8'h00; fb[3] = 8'h00; fb[4] = 8'h00; fb[5] = 8'h0A;
      m = 16'hFFFF;
      for (int i = 0; i < 6; i++) m = ref_upd(m, fb[i]);
      check(m == 16'hCDC5, "R5 model vector", {1'b0, m}, 17'h0CDC5);
      send_frame(1'b0, 6, 1'b0, 1'b1, 1'b0);
      check(crc_o == 16'hCDC5, "R5 crc after known frame", {1'b0, crc_o}, 17'h0CDC5);

      // R2 preset on sof
      send_sof();
      check(crc_o == 16'hFFFF, "R2 preset after sof", {1'b0, crc_o}, 17'h0FFFF);

      // R7 receive good frame and corrupted frame
      fb[6] = 8'hC5; fb[7] = 8'hCD;
      send_frame(1'b1, 8, 1'b0, 1'b0, 1'b0);
      fb[7] = 8'hCC;
      send_frame(1'b1, 8, 1'b0, 1'b0, 1'b0);

      // R8 short receive frame with a valid check field (5 bytes)
      fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33; append_crc(3);
      send_frame(1'b1, 5, 1'b0, 1'b0, 1'b0);
      // R8 transmit body of 3 (too short) and 4 (boundary)
      send_frame(1'b0, 3, 1'b0, 1'b0, 1'b0);
      fb[3] = 8'h44;
      send_frame(1'b0, 4, 1'b0, 1'b0, 1'b0);

      // R10 sof merged with first byte, valid receive frame of 6
      fb[0] = 8'hA5; fb[1] = 8'h0F; fb[2] = 8'hF0; fb[3] = 8'h3C; append_crc(4);
      send_frame(1'b1, 6, 1'b1, 1'b0, 1'b0);

      // R4 R9 stray inputs while busy
      send_frame(1'b1, 6, 1'b0, 1'b0, 1'b1);

      // Varied frames from an LFSR
      for (int k = 0; k < 6; k++) begin
         int n = 4 + k;
         for (int i = 0; i < n; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            fb[i] = lf[7:0];
         end
         if (k % 2 == 0) begin
            append_crc(n);
            send_frame(1'b1, n + 2, (k == 2), 1'b0, 1'b0);
         end else begin
            send_frame(1'b0, n, 1'b0, 1'b0, 1'b0);
         end
      end

      repeat (20) @(negedge clk);
      check(sb_q.size() == 0, "R6 R7 all expected results seen", 17'(sb_q.size()), '0);
      finish_run();
   end
endmodule